// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a forwarding cache-coherence protocol. It owns a small directory that records, for every memory block it is home for, whether the block is uncached, held read-only by a set of nodes, or held writable by a single node. Incoming requests to read or modify a block are answered from that record. The controller sends a response straight to the requester, fans out invalidations to sharers, or forwards the request to the node that holds the block writable. That owner then answers the requester directly, and the home node supplies no data.

The controller produces only two kinds of message: forwards and responses. It never originates a request, so a response can never set off new requests through this block. A forwarded transaction leaves the block marked busy. Further requests to that block wait until the owner reports completion on the update input, and the directory then moves to its final state. Requests to other blocks go ahead in the meantime. Invalidations for a write to a shared block go out one per cycle in ascending node order, and the exclusive response comes after them.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block is uncached, no message is emitted and `req_ready` is high.
- R2: A read to an uncached block returns, on the cycle after acceptance, a Response (`msg_kind`=2, `msg_sub`=0, shared grant) to the requester, and the block becomes shared by that node alone.
- R3: A write to an uncached block, or any request from the current owner of an exclusive block, returns a Response with `msg_sub`=1 (exclusive grant) to the requester, and the requester is recorded as owner.
- R4: A read to a shared block adds the requester to the sharers and returns a shared-grant Response with no Forward.
- R5: A write to a shared block sends one invalidate Forward (`msg_kind`=1, `msg_sub`=1) per cycle to every sharer other than the requester, in ascending node ID, then an exclusive-grant Response to the requester. If the requester is the only sharer, only the Response is sent.
- R6: A request to a block held exclusive by another node emits one Forward (`msg_kind`=1, `msg_sub`=0) to the owner with `msg_req` naming the requester, and the home sends no Response.
- R7: While a forwarded transaction on a block is open, `req_ready` is low for requests to that block. Requests to other blocks are still accepted, including in the cycle an update arrives.
- R8: An update for an open block closes it. After a forwarded read the block is shared by the old owner and the requester. After a forwarded write the requester owns it exclusively.
- R9: Every message emitted has kind Forward (1) or Response (2), never Request (0), and each message matches a request.
- R10: An update for a block with no open forwarded transaction changes nothing.
- R11: While an invalidate sequence is running, `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = modify, 0 = read |
| req_src | input | NW | Requesting node ID |
| req_blk | input | BW | Block index |
| upd_valid | input | 1 | Owner completion for a forwarded transaction |
| upd_blk | input | BW | Block the completion refers to |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 2 | 1 = Forward, 2 = Response |
| msg_sub | output | 1 | Forward: 0 transfer, 1 invalidate; Response: 0 shared, 1 exclusive |
| msg_dst | output | NW | Destination node |
| msg_req | output | NW | Original requester |
| msg_blk | output | BW | Block index |

## Verification
An owner completion and the acceptance of a new request can fall in the same cycle, and both write the directory. The bench provokes this twice. In the first case, the update closes a forwarded write while a read to another block is accepted in the same cycle. The bench judges it by the shared response for the other block and by a later forward to the new owner. In the second case, the update arrives together with a request to the same still-open block. The bench expects `req_ready` low in that cycle, acceptance in the next cycle, and invalidates that reflect the committed sharer set.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    DS_INV = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_e;

  localparam logic [1:0] MK_REQUEST  = 2'd0;
  localparam logic [1:0] MK_FORWARD  = 2'd1;
  localparam logic [1:0] MK_RESPONSE = 2'd2;

  // index of the lowest set bit, 0 when none
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/coh_inv_walk.sv
module coh_inv_walk
  import coh_dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] load_vec,
  input  logic             step,
  output logic             pending,
  output logic [NW-1:0]    cur_id
);

  logic [NODES-1:0] vec_q;

  assign pending = |vec_q;
  assign cur_id  = NW'(lowest_set(32'(vec_q)));

  always_ff @(posedge clk) begin
    if (!rst_n)    vec_q <= '0;
    else if (load) vec_q <= load_vec;
    else if (step) vec_q <= vec_q & ~(NODES'(1) << cur_id);
  end

  // R5: each step retires exactly one sharer
  p_one_per_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pending) |=> ($countones(vec_q) == $countones($past(vec_q)) - 1));

  // R5: invalidation targets rise strictly
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ($countones(vec_q) > 1)) |=> (cur_id > $past(cur_id)));

endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int NW     = 2,
  parameter int BW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BW-1:0]     rd_blk,
  output dstate_e           rd_st,
  output logic [NODES-1:0]  rd_vec,
  output logic [NW-1:0]     rd_own,
  output logic [BLOCKS-1:0] pend_vec,
  input  logic              wa_en,
  input  logic [BW-1:0]     wa_blk,
  input  dstate_e           wa_st,
  input  logic [NODES-1:0]  wa_vec,
  input  logic [NW-1:0]     wa_own,
  input  logic              wa_pset,
  input  logic [NW-1:0]     wa_psrc,
  input  logic              wa_pwr,
  input  logic              ub_en,
  input  logic [BW-1:0]     ub_blk,
  output logic              commit_evt
);

  dstate_e          st_q   [BLOCKS];
  logic [NODES-1:0] vec_q  [BLOCKS];
  logic [NW-1:0]    own_q  [BLOCKS];
  logic [NW-1:0]    psrc_q [BLOCKS];
  logic [BLOCKS-1:0] pwr_q;
  logic [BLOCKS-1:0] pend_q;

  assign rd_st      = st_q[rd_blk];
  assign rd_vec     = vec_q[rd_blk];
  assign rd_own     = own_q[rd_blk];
  assign pend_vec   = pend_q;
  assign commit_evt = ub_en && pend_q[ub_blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      pend_q <= '0;
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b]   <= DS_INV;
        vec_q[b]  <= '0;
        own_q[b]  <= '0;
        psrc_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < BLOCKS; b++) begin
        if (commit_evt && ub_blk == BW'(b)) begin
          pend_q[b] <= 1'b0;
          if (pwr_q[b]) begin
            st_q[b]  <= DS_EXC;
            vec_q[b] <= NODES'(1) << psrc_q[b];
            own_q[b] <= psrc_q[b];
          end else begin
            st_q[b]  <= DS_SHR;
            vec_q[b] <= (NODES'(1) << own_q[b]) | (NODES'(1) << psrc_q[b]);
          end
        end else if (wa_en && wa_blk == BW'(b)) begin
          st_q[b]   <= wa_st;
          vec_q[b]  <= wa_vec;
          own_q[b]  <= wa_own;
          pend_q[b] <= wa_pset;
          psrc_q[b] <= wa_psrc;
          pwr_q[b]  <= wa_pwr;
        end
      end
    end
  end

  // R7: the request path never rewrites a block with an open forward
  p_write_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wa_en |-> !pend_q[wa_blk]);

  // R8: a completion closes its block
  p_commit_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !pend_q[$past(ub_blk)]);

  // R10: a stray completion leaves the entry alone
  p_stray_upd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ub_en && !pend_q[ub_blk] && !(wa_en && wa_blk == ub_blk))
      |=> (st_q[$past(ub_blk)] == $past(st_q[ub_blk])) &&
          (vec_q[$past(ub_blk)] == $past(vec_q[ub_blk])));

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int NW = (NODES  > 1) ? $clog2(NODES)  : 1,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [NW-1:0] req_src,
  input  logic [BW-1:0] req_blk,
  input  logic          upd_valid,
  input  logic [BW-1:0] upd_blk,
  output logic          msg_valid,
  output logic [1:0]    msg_kind,
  output logic          msg_sub,
  output logic [NW-1:0] msg_dst,
  output logic [NW-1:0] msg_req,
  output logic [BW-1:0] msg_blk
);

  typedef enum logic {C_IDLE, C_WALK} cstate_e;

  cstate_e       state_q;
  logic [NW-1:0] wreq_q;
  logic [BW-1:0] wblk_q;

  dstate_e           rd_st;
  logic [NODES-1:0]  rd_vec;
  logic [NW-1:0]     rd_own;
  logic [BLOCKS-1:0] pend_vec;
  logic              commit_evt;

  logic              wa_en, wa_pset, wa_pwr;
  logic [BW-1:0]     wa_blk;
  dstate_e           wa_st;
  logic [NODES-1:0]  wa_vec;
  logic [NW-1:0]     wa_own, wa_psrc;

  logic              w_load, w_step, w_pending;
  logic [NW-1:0]     w_cur;

  logic              m_valid, m_sub, go_walk, go_idle;
  logic [1:0]        m_kind;
  logic [NW-1:0]     m_dst, m_req;
  logic [BW-1:0]     m_blk;

  logic              accept;
  logic [NODES-1:0]  src_oh, others;

  coh_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .NW(NW), .BW(BW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_blk), .rd_st(rd_st), .rd_vec(rd_vec), .rd_own(rd_own),
    .pend_vec(pend_vec),
    .wa_en(wa_en), .wa_blk(wa_blk), .wa_st(wa_st), .wa_vec(wa_vec),
    .wa_own(wa_own), .wa_pset(wa_pset), .wa_psrc(wa_psrc), .wa_pwr(wa_pwr),
    .ub_en(upd_valid), .ub_blk(upd_blk), .commit_evt(commit_evt)
  );

  coh_inv_walk #(.NODES(NODES), .NW(NW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(w_load), .load_vec(others), .step(w_step),
    .pending(w_pending), .cur_id(w_cur)
  );

  assign req_ready = (state_q == C_IDLE) && !pend_vec[req_blk];
  assign accept    = req_valid && req_ready;
  assign src_oh    = NODES'(1) << req_src;
  assign others    = rd_vec & ~src_oh;

  always_comb begin
    wa_en   = 1'b0;
    wa_blk  = req_blk;
    wa_st   = rd_st;
    wa_vec  = rd_vec;
    wa_own  = rd_own;
    wa_pset = 1'b0;
    wa_psrc = req_src;
    wa_pwr  = req_write;
    m_valid = 1'b0;
    m_kind  = MK_RESPONSE;
    m_sub   = 1'b0;
    m_dst   = req_src;
    m_req   = req_src;
    m_blk   = req_blk;
    w_load  = 1'b0;
    w_step  = 1'b0;
    go_walk = 1'b0;
    go_idle = 1'b0;
    if (state_q == C_IDLE) begin
      if (accept) begin
        case (rd_st)
          DS_SHR: begin
            if (!req_write) begin
              wa_en   = 1'b1;
              wa_vec  = rd_vec | src_oh;
              m_valid = 1'b1;
            end else if (others == '0) begin
              wa_en   = 1'b1;
              wa_st   = DS_EXC;
              wa_vec  = src_oh;
              wa_own  = req_src;
              m_valid = 1'b1;
              m_sub   = 1'b1;
            end else begin
              w_load  = 1'b1;
              go_walk = 1'b1;
            end
          end
          DS_EXC: begin
            if (rd_own == req_src) begin
              m_valid = 1'b1;
              m_sub   = 1'b1;
            end else begin
              wa_en   = 1'b1;
              wa_pset = 1'b1;
              m_valid = 1'b1;
              m_kind  = MK_FORWARD;
              m_dst   = rd_own;
            end
          end
          default: begin
            wa_en   = 1'b1;
            wa_vec  = src_oh;
            wa_own  = req_src;
            wa_st   = req_write ? DS_EXC : DS_SHR;
            m_valid = 1'b1;
            m_sub   = req_write;
          end
        endcase
      end
    end else begin
      m_req = wreq_q;
      m_blk = wblk_q;
      if (w_pending) begin
        w_step  = 1'b1;
        m_valid = 1'b1;
        m_kind  = MK_FORWARD;
        m_sub   = 1'b1;
        m_dst   = w_cur;
      end else begin
        wa_en   = 1'b1;
        wa_blk  = wblk_q;
        wa_st   = DS_EXC;
        wa_vec  = NODES'(1) << wreq_q;
        wa_own  = wreq_q;
        wa_psrc = wreq_q;
        wa_pwr  = 1'b1;
        m_valid = 1'b1;
        m_sub   = 1'b1;
        m_dst   = wreq_q;
        go_idle = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= C_IDLE;
      wreq_q    <= '0;
      wblk_q    <= '0;
      msg_valid <= 1'b0;
      msg_kind  <= MK_RESPONSE;
      msg_sub   <= 1'b0;
      msg_dst   <= '0;
      msg_req   <= '0;
      msg_blk   <= '0;
    end else begin
      if (go_walk) begin
        state_q <= C_WALK;
        wreq_q  <= req_src;
        wblk_q  <= req_blk;
      end else if (go_idle) begin
        state_q <= C_IDLE;
      end
      msg_valid <= m_valid;
      msg_kind  <= m_kind;
      msg_sub   <= m_sub;
      msg_dst   <= m_dst;
      msg_req   <= m_req;
      msg_blk   <= m_blk;
    end
  end

  // R9: only Forward and Response leave the home node
  p_no_request_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_kind == MK_FORWARD || msg_kind == MK_RESPONSE));

  // R5: the requester is never invalidated
  p_inv_not_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MK_FORWARD && msg_sub) |-> (msg_dst != msg_req));

  // R6: a transfer forward goes to another node than the requester
  p_fwd_not_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MK_FORWARD && !msg_sub) |-> (msg_dst != msg_req));

  // R7: an open block refuses requests
  p_pend_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pend_vec[req_blk]) |-> !accept);

  // R11: a walk entered from idle refuses the next request
  p_walk_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go_walk |=> !req_ready);

endmodule

// File: tb/tb_coh_home_dir.sv
module tb_coh_home_dir;

  localparam int N  = 4;
  localparam int B  = 8;
  localparam int NW = 2;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [NW-1:0] req_src = '0;
  logic [BW-1:0] req_blk = '0;
  logic          upd_valid = 1'b0;
  logic [BW-1:0] upd_blk = '0;
  logic          msg_valid;
  logic [1:0]    msg_kind;
  logic          msg_sub;
  logic [NW-1:0] msg_dst, msg_req;
  logic [BW-1:0] msg_blk;

  coh_home_dir #(.NODES(N), .BLOCKS(B)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_src(req_src), .req_blk(req_blk),
    .upd_valid(upd_valid), .upd_blk(upd_blk),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_sub(msg_sub),
    .msg_dst(msg_dst), .msg_req(msg_req), .msg_blk(msg_blk)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]    k;
    logic          s;
    logic [NW-1:0] d;
    logic [NW-1:0] r;
    logic [BW-1:0] b;
  } item_t;

  item_t expq[$];
  string tagq[$];
  int checks = 0;
  int errors = 0;
  bit mon_on = 0;

  // reference directory: 0 uncached, 1 shared, 2 exclusive
  int         mst   [B];
  logic [N-1:0] mvec [B];
  int         mown  [B];
  bit         mpend [B];
  int         mpsrc [B];
  bit         mpwr  [B];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int s, input int d, input int r,
                      input int b, input string tag);
    item_t it;
    it.k = 2'(k); it.s = 1'(s); it.d = NW'(d); it.r = NW'(r); it.b = BW'(b);
    expq.push_back(it);
    tagq.push_back(tag);
  endtask

  task automatic model_accept(input bit w, input int src, input int blk, input string tag);
    if (mst[blk] == 0) begin
      push(2, w, src, src, blk, tag);
      mst[blk] = w ? 2 : 1;
      mvec[blk] = '0; mvec[blk][src] = 1'b1;
      mown[blk] = src;
    end else if (mst[blk] == 1) begin
      if (!w) begin
        mvec[blk][src] = 1'b1;
        push(2, 0, src, src, blk, tag);
      end else begin
        for (int i = 0; i < N; i++)
          if (mvec[blk][i] && i != src) push(1, 1, i, src, blk, tag);
        push(2, 1, src, src, blk, tag);
        mst[blk] = 2;
        mvec[blk] = '0; mvec[blk][src] = 1'b1;
        mown[blk] = src;
      end
    end else begin
      if (mown[blk] == src) push(2, 1, src, src, blk, tag);
      else begin
        push(1, 0, mown[blk], src, blk, tag);
        mpend[blk] = 1; mpsrc[blk] = src; mpwr[blk] = w;
      end
    end
  endtask

  task automatic model_commit(input int blk);
    if (mpend[blk]) begin
      mpend[blk] = 0;
      if (mpwr[blk]) begin
        mst[blk] = 2; mown[blk] = mpsrc[blk];
        mvec[blk] = '0; mvec[blk][mpsrc[blk]] = 1'b1;
      end else begin
        mst[blk] = 1;
        mvec[blk] = '0; mvec[blk][mown[blk]] = 1'b1; mvec[blk][mpsrc[blk]] = 1'b1;
      end
    end
  endtask

  task automatic probe_low(input int blk, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_src = '0; req_blk = BW'(blk);
    #1;
    check(req_ready == 1'b0, tag, "req_ready while busy", 32'(req_ready), 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic step(input bit w, input int src, input int blk, input bit do_u,
                      input int ublk, input bit probe, input string tag);
    bit acc, exp_rdy, u;
    int tries;
    acc = 0; tries = 0; u = do_u;
    while (!acc && tries < 4) begin
      tries++;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_src = NW'(src); req_blk = BW'(blk);
      upd_valid = u; upd_blk = BW'(ublk);
      #1;
      exp_rdy = !mpend[blk];
      check(req_ready == exp_rdy, "R7", "req_ready", 32'(req_ready), 32'(exp_rdy));
      if (exp_rdy) begin
        model_accept(w, src, blk, tag);
        acc = 1;
      end
      if (u) begin
        model_commit(ublk);
        u = 0;
      end
      @(posedge clk); #1;
      req_valid = 1'b0; upd_valid = 1'b0;
    end
    if (probe) probe_low(7, "R11");
    wait (expq.size() == 0);
  endtask

  task automatic upd_only(input int blk);
    @(negedge clk);
    upd_valid = 1'b1; upd_blk = BW'(blk);
    model_commit(blk);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares every emitted message against the queue
  always @(negedge clk) begin
    item_t g, e;
    string t;
    if (mon_on && msg_valid) begin
      g.k = msg_kind; g.s = msg_sub; g.d = msg_dst; g.r = msg_req; g.b = msg_blk;
      if (expq.size() == 0) begin
        check(1'b0, "R9", "unexpected message", 32'(g), 0);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        check(g == e, t, "message", 32'(g), 32'(e));
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < B; b++) begin
      mst[b] = 0; mvec[b] = '0; mown[b] = 0; mpend[b] = 0; mpsrc[b] = 0; mpwr[b] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(msg_valid == 1'b0, "R1", "msg_valid after reset", 32'(msg_valid), 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
    mon_on = 1;

    step(0, 1, 0, 0, 0, 0, "R2");
    step(0, 3, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 1, "R5");   // invalidates 0 and 3, R11 probe
    step(1, 1, 0, 0, 0, 0, "R3");   // owner rewrites
    step(1, 2, 2, 0, 0, 0, "R3");   // write to uncached
    step(0, 2, 0, 0, 0, 0, "R6");   // forward to owner 1
    probe_low(0, "R7");
    step(0, 0, 5, 0, 0, 0, "R7");   // other block proceeds
    upd_only(0);                    // R8: read commit -> shared {1,2}
    step(1, 3, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, "R6");   // forwarded write to owner 3
    step(0, 2, 5, 1, 0, 0, "R7");   // update and other-block request together
    step(0, 1, 0, 0, 0, 0, "R8");   // owner is now 0
    step(1, 2, 0, 1, 0, 0, "R8");   // update arrives with stalled request
    upd_only(2);                    // R10: block 2 not open
    step(0, 3, 2, 0, 0, 0, "R10");  // still exclusive to node 2
    upd_only(2);
    step(0, 2, 6, 0, 0, 0, "R4");
    step(1, 2, 6, 0, 0, 0, "R5");   // sole sharer upgrades
    step(1, 3, 5, 0, 0, 0, "R5");   // non-sharer write on {0,2}
    step(1, 3, 2, 0, 0, 0, "R5");   // block 2 shared {2,3}

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R9", "pending expectations", 32'(expq.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule